// File: doc/BRIEF.md
# SPI Master Transfer Engine

This block is the serial core of an SPI master. A byte-wide transmit FIFO feeds a shifter that drives SCLK and MOSI in SPI mode 0. Every byte clocked out brings one byte back from MISO, and that byte goes into a byte-wide receive FIFO. Surrounding logic pushes bytes into one FIFO and pops them from the other. Two static configuration inputs set the rest of the behaviour. The first chooses who drives the single active-low slave select: the engine, or a software level supplied on a pin. The second chooses how a transfer starts: as soon as data is present, or only when a one-cycle start pulse arrives.

When the engine drives slave select, the line stays low for as long as the transmit FIFO keeps supplying bytes. Bytes follow each other with no break in SCLK. The line rises only after the FIFO runs dry and the last byte has finished. SCLK runs at the system clock divided by `CLK_DIV`, which must be even. The block also reports both FIFO levels, full and empty flags, a threshold-based transmit room flag, and two sticky overflow flags that one clear pulse resets.

Top module: `spim_core`

## Requirements
- R1: When `cfg_sw_cs` is 1, `ss_n` equals `sw_cs_n` in the same cycle, and transfers never change it.
- R2: When `cfg_sw_cs` is 0, `ss_n` is high while the engine is idle. It is low from the clock edge that starts a transfer until the transfer ends.
- R3: With engine-driven select, H = `CLK_DIV`/2 system cycles pass between the fall of `ss_n` and the first SCLK rising edge. H cycles also pass between the last SCLK falling edge and the rise of `ss_n`. The rise happens only once the transmit FIFO is empty.
- R4: A byte present in the transmit FIFO when the current byte ends is sent next without a gap. SCLK keeps its period and `ss_n` stays low.
- R5: With `cfg_man_start` = 0, an idle engine starts a transfer on the first clock edge at which the transmit FIFO holds at least one byte.
- R6: With `cfg_man_start` = 1, bytes wait in the transmit FIFO until `start_pulse` is high on an edge while the engine is idle. The engine then sends bytes until the FIFO is empty. A start pulse while the FIFO is empty has no effect.
- R7: `tx_not_full` is 1 exactly when `tx_level` is less than `tx_thresh`.
- R8: `rx_full` is 1 exactly when `rx_level` equals `DEPTH` (128 by default). The transmit FIFO has the same depth.
- R9: Bytes are sent MSB first in SPI mode 0. SCLK idles low. MOSI changes only with the falling SCLK edge and holds its value while SCLK is high. MISO is sampled on the edge that raises SCLK. SCLK high and low phases each last H cycles.
- R10: Each completed byte is pushed into the receive FIFO. If that FIFO is full, the byte is dropped, the stored bytes are kept, and `rx_ovf` sets and stays set until `ovf_clr`.
- R11: A write while the transmit FIFO is full is ignored and sets `tx_ovf`, which stays set until `ovf_clr`. A set event has priority over a clear in the same cycle.
- R12: After reset, `ss_n` is high (engine-driven select), SCLK and MOSI are low, both FIFOs are empty, and both overflow flags are clear.
- R13: Both FIFOs keep first-in first-out order. `rx_data` shows the oldest received byte whenever `rx_empty` is 0. A read of an empty receive FIFO is ignored, and the levels count the bytes held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_sw_cs | input | 1 | 1: slave select comes from `sw_cs_n` |
| cfg_man_start | input | 1 | 1: transfers wait for `start_pulse` |
| sw_cs_n | input | 1 | Software slave-select level |
| start_pulse | input | 1 | One-cycle start command |
| tx_thresh | input | LVL_W | Threshold for `tx_not_full` |
| tx_wr | input | 1 | Push `tx_data` into the transmit FIFO |
| tx_data | input | 8 | Byte to transmit |
| rx_rd | input | 1 | Pop the oldest received byte |
| rx_data | output | 8 | Oldest received byte |
| ovf_clr | input | 1 | Clears both overflow flags |
| miso | input | 1 | Serial data from slave |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to slave |
| ss_n | output | 1 | Active-low slave select |
| tx_level | output | LVL_W | Bytes held in transmit FIFO |
| rx_level | output | LVL_W | Bytes held in receive FIFO |
| tx_full | output | 1 | Transmit FIFO full |
| tx_empty | output | 1 | Transmit FIFO empty |
| tx_not_full | output | 1 | Transmit level below threshold |
| rx_full | output | 1 | Receive FIFO full |
| rx_empty | output | 1 | Receive FIFO empty |
| tx_ovf | output | 1 | Sticky transmit overflow |
| rx_ovf | output | 1 | Sticky receive overflow |

## Verification
The bench builds the block with `DEPTH` = 16 and `CLK_DIV` = 6. The smaller depth lets the bench fill the transmit FIFO past its limit and fill the receive FIFO to full within a short run. With H = 3, an off-by-one in the half-period counter moves SCLK edges by a visible cycle, and the select-to-clock spacing becomes distinct from the divider's minimum. A behavioural timeline model built on byte queues predicts every output in every cycle, including the MISO bits captured from a pseudo-random stream.

// File: rtl/spim_pkg.sv
package spim_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_SHIFT = 2'd2,
        ST_TRAIL = 2'd3
    } spim_state_e;

    typedef struct packed {
        logic full;
        logic empty;
    } spim_fifo_stat_t;

    typedef struct packed {
        logic              valid;
        logic [BYTE_W-1:0] data;
    } spim_byte_evt_t;

    typedef struct packed {
        logic sclk;
        logic mosi;
    } spim_pins_t;

    // sticky flag update: a set event beats a clear in the same cycle
    function automatic logic spim_sticky(input logic cur, input logic set, input logic clr);
        if (set)
            return 1'b1;
        else if (clr)
            return 1'b0;
        else
            return cur;
    endfunction

endpackage

// File: rtl/spim_fifo.sv
module spim_fifo
    import spim_pkg::*;
#(
    parameter int DEPTH = 128,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              rd,
    output logic [BYTE_W-1:0] rdata,
    output logic [LVL_W-1:0]  level,
    output spim_fifo_stat_t   stat
);

    logic [BYTE_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wptr, rptr;
    logic              do_wr, do_rd;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        if (p == PTR_W'(DEPTH - 1))
            return '0;
        else
            return p + PTR_W'(1);
    endfunction

    assign stat.full  = (level == LVL_W'(DEPTH));
    assign stat.empty = (level == '0);
    assign do_wr      = wr && !stat.full;
    assign do_rd      = rd && !stat.empty;
    assign rdata      = mem[rptr];

    always_ff @(posedge clk) begin
        if (do_wr)
            mem[wptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            level <= '0;
        end else begin
            if (do_wr)
                wptr <= bump(wptr);
            if (do_rd)
                rptr <= bump(rptr);
            case ({do_wr, do_rd})
                2'b10:   level <= level + LVL_W'(1);
                2'b01:   level <= level - LVL_W'(1);
                default: level <= level;
            endcase
        end
    end

    // R13: the level never passes the storage size
    a_r13_level_bound: assert property (@(posedge clk) disable iff (rst)
        level <= LVL_W'(DEPTH));

    // R11: a push into a full FIFO without a pop leaves it full
    a_r11_full_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (stat.full && wr && !rd) |=> (level == LVL_W'(DEPTH)));

endmodule

// File: rtl/spim_divider.sv
module spim_divider #(
    parameter int CLK_DIV = 4,
    localparam int HALF  = CLK_DIV / 2,
    localparam int HC_W  = (HALF > 1) ? $clog2(HALF) : 1
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);

    logic [HC_W-1:0] hcnt;
    logic            at_end;

    assign at_end = (hcnt == HC_W'(HALF - 1));
    assign tick   = run && at_end;

    always_ff @(posedge clk) begin
        if (rst || !run)
            hcnt <= '0;
        else if (at_end)
            hcnt <= '0;
        else
            hcnt <= hcnt + HC_W'(1);
    end

endmodule

// File: rtl/spim_engine.sv
module spim_engine
    import spim_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              man_start,
    input  logic              start_pulse,
    input  logic              tx_avail,
    input  logic [BYTE_W-1:0] tx_head,
    input  logic              miso,
    output logic              tx_pop,
    output spim_byte_evt_t    rx_evt,
    output spim_pins_t        pins,
    output logic              busy
);

    spim_state_e       st;
    logic [BYTE_W-1:0] sh;
    logic [BYTE_W-1:0] rxsh;
    logic [2:0]        bitn;
    logic              sclk_q, mosi_q;
    logic              go, byte_done;

    assign go        = (st == ST_IDLE) && tx_avail && (!man_start || start_pulse);
    assign byte_done = (st == ST_SHIFT) && tick && sclk_q && (bitn == 3'd7);
    assign tx_pop    = go || (byte_done && tx_avail);
    assign rx_evt.valid = byte_done;
    assign rx_evt.data  = rxsh;
    assign pins.sclk = sclk_q;
    assign pins.mosi = mosi_q;
    assign busy      = (st != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            sh     <= '0;
            rxsh   <= '0;
            bitn   <= '0;
            sclk_q <= 1'b0;
            mosi_q <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (go) begin
                        st     <= ST_LEAD;
                        sh     <= tx_head;
                        mosi_q <= tx_head[BYTE_W-1];
                        bitn   <= '0;
                    end
                end
                ST_LEAD: begin
                    if (tick) begin
                        st     <= ST_SHIFT;
                        sclk_q <= 1'b1;
                        rxsh   <= {rxsh[BYTE_W-2:0], miso};
                    end
                end
                ST_SHIFT: begin
                    if (tick) begin
                        if (sclk_q) begin
                            sclk_q <= 1'b0;
                            if (bitn == 3'd7) begin
                                if (tx_avail) begin
                                    sh     <= tx_head;
                                    mosi_q <= tx_head[BYTE_W-1];
                                    bitn   <= '0;
                                end else begin
                                    st <= ST_TRAIL;
                                end
                            end else begin
                                bitn   <= bitn + 3'd1;
                                sh     <= {sh[BYTE_W-2:0], 1'b0};
                                mosi_q <= sh[BYTE_W-2];
                            end
                        end else begin
                            sclk_q <= 1'b1;
                            rxsh   <= {rxsh[BYTE_W-2:0], miso};
                        end
                    end
                end
                default: begin
                    if (tick)
                        st <= ST_IDLE;
                end
            endcase
        end
    end

    // R9: SCLK is low in every state other than shifting
    a_r9_sclk_low_outside_shift: assert property (@(posedge clk) disable iff (rst)
        (st != ST_SHIFT) |-> !sclk_q);

    // R9: MOSI holds while SCLK stays high
    a_r9_mosi_stable_high: assert property (@(posedge clk) disable iff (rst)
        (sclk_q && $past(sclk_q)) |-> $stable(mosi_q));

    // R3: a byte in flight always passes through the trailing gap before idle
    a_r3_no_idle_from_shift: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SHIFT) |=> (st != ST_IDLE));

    // R6: with commanded start, no transfer begins without the pulse
    a_r6_wait_for_start: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && man_start && !start_pulse) |=> (st == ST_IDLE));

endmodule

// File: rtl/spim_core.sv
module spim_core
    import spim_pkg::*;
#(
    parameter int DEPTH   = 128,
    parameter int CLK_DIV = 4,
    localparam int LVL_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_sw_cs,
    input  logic              cfg_man_start,
    input  logic              sw_cs_n,
    input  logic              start_pulse,
    input  logic [LVL_W-1:0]  tx_thresh,
    input  logic              tx_wr,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              rx_rd,
    output logic [BYTE_W-1:0] rx_data,
    input  logic              ovf_clr,
    input  logic              miso,
    output logic              sclk,
    output logic              mosi,
    output logic              ss_n,
    output logic [LVL_W-1:0]  tx_level,
    output logic [LVL_W-1:0]  rx_level,
    output logic              tx_full,
    output logic              tx_empty,
    output logic              tx_not_full,
    output logic              rx_full,
    output logic              rx_empty,
    output logic              tx_ovf,
    output logic              rx_ovf
);

    spim_fifo_stat_t   tx_stat, rx_stat;
    logic [BYTE_W-1:0] tx_head;
    logic              tx_pop, tick, busy;
    spim_byte_evt_t    rx_evt;
    spim_pins_t        pins;

    spim_fifo #(.DEPTH(DEPTH)) u_txq (
        .clk   (clk),
        .rst   (rst),
        .wr    (tx_wr),
        .wdata (tx_data),
        .rd    (tx_pop),
        .rdata (tx_head),
        .level (tx_level),
        .stat  (tx_stat)
    );

    spim_fifo #(.DEPTH(DEPTH)) u_rxq (
        .clk   (clk),
        .rst   (rst),
        .wr    (rx_evt.valid),
        .wdata (rx_evt.data),
        .rd    (rx_rd),
        .rdata (rx_data),
        .level (rx_level),
        .stat  (rx_stat)
    );

    spim_divider #(.CLK_DIV(CLK_DIV)) u_div (
        .clk  (clk),
        .rst  (rst),
        .run  (busy),
        .tick (tick)
    );

    spim_engine u_eng (
        .clk         (clk),
        .rst         (rst),
        .tick        (tick),
        .man_start   (cfg_man_start),
        .start_pulse (start_pulse),
        .tx_avail    (!tx_stat.empty),
        .tx_head     (tx_head),
        .miso        (miso),
        .tx_pop      (tx_pop),
        .rx_evt      (rx_evt),
        .pins        (pins),
        .busy        (busy)
    );

    assign sclk        = pins.sclk;
    assign mosi        = pins.mosi;
    assign ss_n        = cfg_sw_cs ? sw_cs_n : !busy;
    assign tx_full     = tx_stat.full;
    assign tx_empty    = tx_stat.empty;
    assign rx_full     = rx_stat.full;
    assign rx_empty    = rx_stat.empty;
    assign tx_not_full = (tx_level < tx_thresh);

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_ovf <= 1'b0;
            rx_ovf <= 1'b0;
        end else begin
            tx_ovf <= spim_sticky(tx_ovf, tx_wr && tx_stat.full, ovf_clr);
            rx_ovf <= spim_sticky(rx_ovf, rx_evt.valid && rx_stat.full, ovf_clr);
        end
    end

    // R10: the receive overflow flag holds until cleared
    a_r10_rx_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        (rx_ovf && !ovf_clr) |=> rx_ovf);

    // R11: a write into a full transmit FIFO raises the flag
    a_r11_tx_ovf_sets: assert property (@(posedge clk) disable iff (rst)
        (tx_wr && tx_full) |=> tx_ovf);

    // R2: an engine-driven select is low whenever SCLK is high
    a_r2_select_covers_clock: assert property (@(posedge clk) disable iff (rst)
        (!cfg_sw_cs && sclk) |-> !ss_n);

endmodule

// File: tb/tb_spim_core.sv
module tb_spim_core;

    localparam int DEPTH   = 16;
    localparam int CLK_DIV = 6;
    localparam int H       = CLK_DIV / 2;
    localparam int LVL_W   = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_sw_cs = 1'b0, cfg_man_start = 1'b0, sw_cs_n = 1'b1, start_pulse = 1'b0;
    logic [LVL_W-1:0] tx_thresh = LVL_W'(8);
    logic tx_wr = 1'b0, rx_rd = 1'b0, ovf_clr = 1'b0, miso = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic [7:0] rx_data;
    logic sclk, mosi, ss_n, tx_full, tx_empty, tx_not_full, rx_full, rx_empty, tx_ovf, rx_ovf;
    logic [LVL_W-1:0] tx_level, rx_level;

    always #5 clk = ~clk;

    spim_core #(.DEPTH(DEPTH), .CLK_DIV(CLK_DIV)) dut (
        .clk(clk), .rst(rst), .cfg_sw_cs(cfg_sw_cs), .cfg_man_start(cfg_man_start),
        .sw_cs_n(sw_cs_n), .start_pulse(start_pulse), .tx_thresh(tx_thresh),
        .tx_wr(tx_wr), .tx_data(tx_data), .rx_rd(rx_rd), .rx_data(rx_data),
        .ovf_clr(ovf_clr), .miso(miso), .sclk(sclk), .mosi(mosi), .ss_n(ss_n),
        .tx_level(tx_level), .rx_level(rx_level), .tx_full(tx_full), .tx_empty(tx_empty),
        .tx_not_full(tx_not_full), .rx_full(rx_full), .rx_empty(rx_empty),
        .tx_ovf(tx_ovf), .rx_ovf(rx_ovf)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    // pseudo-random MISO stream, changed away from the sampling edge
    logic [15:0] lfsr = 16'hACE1;
    always @(negedge clk) begin
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        miso <= lfsr[15];
    end

    // behavioural timeline model
    logic [7:0] txq[$];
    logic [7:0] rxq[$];
    int   m_mode = 0;
    int   m_t = 0;
    logic [7:0] cur = 8'h00;
    logic [7:0] rxb = 8'h00;
    bit   m_sclk = 0, m_mosi = 0, m_txovf = 0, m_rxovf = 0;

    always @(posedge clk) begin
        int txs, rxs, j;
        bit push_rx;
        if (rst) begin
            m_mode = 0; m_t = 0; m_sclk = 0; m_mosi = 0;
            txq.delete(); rxq.delete();
            m_txovf = 0; m_rxovf = 0;
        end else begin
            txs = txq.size();
            rxs = rxq.size();
            push_rx = 0;
            if (m_mode == 0) begin
                if (txs > 0 && (!cfg_man_start || start_pulse)) begin
                    cur = txq.pop_front();
                    m_mode = 1; m_t = 0; m_mosi = cur[7];
                end
            end else if (m_mode == 1) begin
                m_t++;
                if (m_t % H == 0) begin
                    j = m_t / H;
                    if (j == 16) begin
                        push_rx = 1;
                        m_sclk = 0;
                        m_t = 0;
                        if (txs > 0) begin
                            cur = txq.pop_front();
                            m_mosi = cur[7];
                        end else begin
                            m_mode = 2;
                        end
                    end else if (j % 2 == 1) begin
                        m_sclk = 1;
                        rxb = {rxb[6:0], miso};
                    end else begin
                        m_sclk = 0;
                        m_mosi = cur[7 - j / 2];
                    end
                end
            end else begin
                m_t++;
                if (m_t == H) m_mode = 0;
            end
            if (rx_rd && rxs > 0) void'(rxq.pop_front());
            if (push_rx && rxs < DEPTH) rxq.push_back(rxb);
            if (push_rx && rxs == DEPTH) m_rxovf = 1;
            else if (ovf_clr) m_rxovf = 0;
            if (tx_wr && txs < DEPTH) txq.push_back(tx_data);
            if (tx_wr && txs == DEPTH) m_txovf = 1;
            else if (ovf_clr) m_txovf = 0;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            chk("R9", "sclk", 32'(sclk), 32'(m_sclk));
            chk("R9", "mosi", 32'(mosi), 32'(m_mosi));
            chk(cfg_sw_cs ? "R1" : "R2", "ss_n", 32'(ss_n),
                32'(cfg_sw_cs ? sw_cs_n : (m_mode == 0)));
            chk("R13", "tx_level", 32'(tx_level), 32'(txq.size()));
            chk("R13", "rx_level", 32'(rx_level), 32'(rxq.size()));
            chk("R13", "tx_empty", 32'(tx_empty), 32'(txq.size() == 0));
            chk("R13", "rx_empty", 32'(rx_empty), 32'(rxq.size() == 0));
            chk("R8", "tx_full", 32'(tx_full), 32'(txq.size() == DEPTH));
            chk("R8", "rx_full", 32'(rx_full), 32'(rxq.size() == DEPTH));
            chk("R7", "tx_not_full", 32'(tx_not_full), 32'(txq.size() < int'(tx_thresh)));
            chk("R11", "tx_ovf", 32'(tx_ovf), 32'(m_txovf));
            chk("R10", "rx_ovf", 32'(rx_ovf), 32'(m_rxovf));
            if (rxq.size() > 0)
                chk("R13", "rx_data", 32'(rx_data), 32'(rxq[0]));
        end
    end

    // event collectors on the serial pins
    int cyc = 0;
    always @(posedge clk) cyc++;
    logic p_sclk = 1'b0, p_ss = 1'b1;
    logic [7:0] cap = 8'h00;
    int n_rise = 0, n_ssfall = 0, n_ssrise = 0;
    int first_rise_cyc = -1, last_fall_cyc = 0, ss_fall_cyc = 0, ss_rise_cyc = 0;

    always @(negedge clk) begin
        if (sclk && !p_sclk) begin
            cap = {cap[6:0], mosi};
            n_rise++;
            if (first_rise_cyc < 0) first_rise_cyc = cyc;
        end
        if (!sclk && p_sclk) last_fall_cyc = cyc;
        if (!ss_n && p_ss) begin n_ssfall++; ss_fall_cyc = cyc; end
        if (ss_n && !p_ss) begin n_ssrise++; ss_rise_cyc = cyc; end
        p_sclk = sclk;
        p_ss = ss_n;
    end

    task automatic clr_col();
        n_rise = 0; n_ssfall = 0; n_ssrise = 0; first_rise_cyc = -1; cap = 8'h00;
    endtask

    task automatic wr_byte(input logic [7:0] b);
        tx_wr = 1'b1; tx_data = b;
        @(posedge clk); #1;
        tx_wr = 1'b0;
    endtask

    task automatic pulse_start();
        start_pulse = 1'b1;
        @(posedge clk); #1;
        start_pulse = 1'b0;
    endtask

    task automatic pulse_clr();
        ovf_clr = 1'b1;
        @(posedge clk); #1;
        ovf_clr = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (!(m_mode == 0 && txq.size() == 0));
        repeat (2) @(negedge clk);
    endtask

    task automatic drain_rx();
        int n = rxq.size();
        @(posedge clk); #1;
        if (n > 0) begin
            rx_rd = 1'b1;
            repeat (n) @(posedge clk);
            #1 rx_rd = 1'b0;
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        chk("R12", "ss_n", 32'(ss_n), 32'd1);
        chk("R12", "sclk", 32'(sclk), 32'd0);
        chk("R12", "mosi", 32'(mosi), 32'd0);
        chk("R12", "tx_empty", 32'(tx_empty), 32'd1);
        chk("R12", "rx_empty", 32'(rx_empty), 32'd1);
        chk("R12", "ovf", 32'({tx_ovf, rx_ovf}), 32'd0);

        // R5 / R9: automatic start, one byte
        @(posedge clk); #1;
        clr_col();
        wr_byte(8'hA5);
        @(negedge clk);
        chk("R5", "ss_n before start edge", 32'(ss_n), 32'd1);
        @(negedge clk);
        chk("R5", "ss_n after start edge", 32'(ss_n), 32'd0);
        wait_idle();
        chk("R9", "captured byte", 32'(cap), 32'hA5);
        chk("R9", "rising edges", 32'(n_rise), 32'd8);
        drain_rx();

        // R3 / R4: three bytes written back to back
        clr_col();
        wr_byte(8'h3C);
        wr_byte(8'hF0);
        wr_byte(8'h81);
        wait_idle();
        chk("R4", "select pulses", 32'(n_ssrise), 32'd1);
        chk("R4", "rising edges", 32'(n_rise), 32'd24);
        chk("R9", "last byte", 32'(cap), 32'h81);
        chk("R3", "lead gap", 32'(first_rise_cyc - ss_fall_cyc), 32'(H));
        chk("R3", "trail gap", 32'(ss_rise_cyc - last_fall_cyc), 32'(H));
        drain_rx();

        // R4: refill while a byte is in flight
        clr_col();
        wr_byte(8'h5A);
        repeat (30) @(posedge clk);
        #1;
        wr_byte(8'hC3);
        wait_idle();
        chk("R4", "select pulses after refill", 32'(n_ssrise), 32'd1);
        chk("R4", "rising edges after refill", 32'(n_rise), 32'd16);
        drain_rx();

        // R6: commanded start
        cfg_man_start = 1'b1;
        clr_col();
        wr_byte(8'h11);
        wr_byte(8'h22);
        repeat (20) @(negedge clk);
        chk("R6", "ss_n waits", 32'(ss_n), 32'd1);
        chk("R6", "bytes wait", 32'(tx_level), 32'd2);
        @(posedge clk); #1;
        pulse_start();
        wait_idle();
        chk("R6", "bytes received", 32'(rx_level), 32'd2);
        chk("R6", "one select pulse", 32'(n_ssrise), 32'd1);
        drain_rx();
        clr_col();
        pulse_start();
        repeat (10) @(negedge clk);
        chk("R6", "empty start ignored", 32'(n_ssfall), 32'd0);

        // R7: threshold flag
        @(posedge clk); #1;
        for (int i = 0; i < 5; i++) wr_byte(8'(8'h40 + i));
        tx_thresh = LVL_W'(5);
        @(negedge clk);
        chk("R7", "level equals threshold", 32'(tx_not_full), 32'd0);
        @(posedge clk); #1 tx_thresh = LVL_W'(6);
        @(negedge clk);
        chk("R7", "level below threshold", 32'(tx_not_full), 32'd1);
        @(posedge clk); #1 tx_thresh = LVL_W'(0);
        @(negedge clk);
        chk("R7", "zero threshold", 32'(tx_not_full), 32'd0);

        // R11: overflow the transmit FIFO
        @(posedge clk); #1;
        for (int i = 0; i < 12; i++) wr_byte(8'(8'h80 + i));
        @(negedge clk);
        chk("R11", "level capped", 32'(tx_level), 32'(DEPTH));
        chk("R11", "tx_ovf set", 32'(tx_ovf), 32'd1);
        @(posedge clk); #1;
        pulse_clr();
        @(negedge clk);
        chk("R11", "tx_ovf cleared", 32'(tx_ovf), 32'd0);

        // R8 / R10: fill and overflow the receive FIFO
        @(posedge clk); #1;
        pulse_start();
        wait_idle();
        chk("R8", "rx_full", 32'(rx_full), 32'd1);
        chk("R8", "rx_level", 32'(rx_level), 32'(DEPTH));
        @(posedge clk); #1;
        wr_byte(8'hEE);
        pulse_start();
        wait_idle();
        chk("R10", "rx_ovf set", 32'(rx_ovf), 32'd1);
        chk("R10", "level kept", 32'(rx_level), 32'(DEPTH));
        chk("R10", "oldest kept", 32'(rx_data), 32'(rxq[0]));
        @(posedge clk); #1;
        pulse_clr();
        @(negedge clk);
        chk("R10", "rx_ovf cleared", 32'(rx_ovf), 32'd0);
        drain_rx();
        @(negedge clk);
        chk("R13", "drained", 32'(rx_empty), 32'd1);
        @(posedge clk); #1 rx_rd = 1'b1;
        @(posedge clk); #1 rx_rd = 1'b0;
        @(negedge clk);
        chk("R13", "empty read ignored", 32'(rx_level), 32'd0);

        // R1: software-driven select
        cfg_man_start = 1'b0;
        cfg_sw_cs = 1'b1;
        sw_cs_n = 1'b1;
        clr_col();
        wr_byte(8'h96);
        wait_idle();
        chk("R1", "no engine select", 32'(n_ssfall), 32'd0);
        chk("R1", "byte still sent", 32'(n_rise), 32'd8);
        @(posedge clk); #1 sw_cs_n = 1'b0;
        @(negedge clk);
        chk("R1", "follows software low", 32'(ss_n), 32'd0);
        @(posedge clk); #1 sw_cs_n = 1'b1;
        @(negedge clk);
        chk("R1", "follows software high", 32'(ss_n), 32'd1);
        drain_rx();

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule